// File: doc/BRIEF.md
# Integrating Converter Sequencer

This block is the digital control for a chopper-stabilised integrating converter. A sensor-select pulse starts a conversion with three steps. First the integrator is cleared for a fixed number of clocks. Then the demodulated signal is integrated for a fixed number of clocks. Last, a constant discharge current is switched on and the block counts clocks until the comparator reports that the integrator has returned to its threshold. That count is the 10-bit result. When the discharge lasts longer than the counter can hold, the count stops at full scale and an overflow flag is raised. The result leaves the block as a serial word, most significant bit first, framed by a valid strobe.

A 9-bit trim code drives the current DAC that cancels the offset of the whole sensing chain. The code changes only during a calibration that the user requests. Calibration runs nine conversions with the input held at zero and decides one trim bit per conversion, from the top bit down. It keeps the code that brings the result closest to mid-scale. The analog parts (integrator, comparator, current sources and DAC) sit outside the block. The block sees them only through the comparator input and its control outputs.

Top module: `intadc_ctrl`

## Requirements
- R1: During and right after reset, int_rst, int_en, dis_en, ser_valid, ser_data, res_ovf and cal_busy are low and trim_code holds 256 (binary 1_0000_0000).
- R2: A sel_pulse seen in idle starts a conversion. int_rst is high for exactly RST_CYC cycles, then int_en for exactly INT_CYC cycles, then dis_en rises. At most one of int_rst, int_en, dis_en and ser_valid is high in any cycle.
- R3: Discharge ends in the first cycle where comp_in is sampled low while dis_en is high. The result is the number of cycles in which comp_in was sampled high during discharge.
- R4: After 1023 high samples the count stops at 1023. A further high sample ends the discharge with result 1023 and res_ovf high. res_ovf is low for any result reached by a low sample.
- R5: After a normal discharge, ser_valid is high for 10 consecutive cycles. ser_data carries the result most significant bit first, and res_ovf is valid while ser_valid is high.
- R6: sel_pulse has no effect while a conversion or a calibration is running. No extra conversion and no extra serial frame follows.
- R7: A cal_req seen in idle raises cal_busy and runs exactly 9 conversions with no serial frame. cal_req wins over a sel_pulse in the same cycle.
- R8: Calibration sets the trial bits from bit 8 down to bit 0. A bit is kept when its conversion result is at least 512 and cleared otherwise. For a chain whose result falls as the code rises, the final code is the largest code whose result is at least 512.
- R9: trim_code changes only while cal_busy is high. A cal_req made while a conversion is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_pulse | input | 1 | Sensor-select event, starts a conversion |
| cal_req | input | 1 | User request for offset calibration |
| comp_in | input | 1 | Comparator, high while the integrator is beyond its threshold |
| int_rst | output | 1 | Integrator reset switch |
| int_en | output | 1 | Integrate phase enable |
| dis_en | output | 1 | Constant discharge current enable |
| ser_valid | output | 1 | Serial result strobe |
| ser_data | output | 1 | Serial result bit, MSB first |
| res_ovf | output | 1 | Discharge count saturated |
| cal_busy | output | 1 | Calibration in progress |
| trim_code | output | 9 | Offset-trim DAC code |

## Verification
The assertions assume that comp_in is a clean synchronous level that settles well before the sampling edge, and that it matters only while dis_en is high. The bench drives comp_in on the falling edge from a behavioural integrator. That model holds the comparator high for a number of discharge cycles equal to a fixed offset plus the test input minus the trim code, clamped at zero, so the result always falls as the code rises. sel_pulse and cal_req are one-cycle pulses driven on the falling edge. Some arrive deliberately in the middle of a conversion or a calibration to show that they are ignored.

// File: rtl/intadc_pkg.sv
package intadc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RSTI = 3'd1,
    ST_INTG = 3'd2,
    ST_DSCH = 3'd3,
    ST_DONE = 3'd4
  } phase_e;
endpackage

// File: rtl/intadc_seq.sv
module intadc_seq
  import intadc_pkg::*;
#(
  parameter int RST_CYC = 4,
  parameter int INT_CYC = 16,
  parameter int RES_W   = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_pulse,
  input  logic cal_req,
  input  logic comp_in,
  input  logic cnt_sat,
  input  logic cal_busy,
  input  logic cal_last,
  output logic start_conv,
  output logic cal_start,
  output logic step_done,
  output logic ser_load,
  output logic int_rst,
  output logic int_en,
  output logic dis_en,
  output logic ser_valid
);
  localparam int TMAX = (RST_CYC > INT_CYC) ? ((RST_CYC > RES_W) ? RST_CYC : RES_W)
                                            : ((INT_CYC > RES_W) ? INT_CYC : RES_W);
  localparam int TMR_W = $clog2(TMAX + 1);

  phase_e phase_q, phase_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic dsch_exit;

  assign dsch_exit = (phase_q == ST_DSCH) && (!comp_in || cnt_sat);

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      ST_IDLE: if (cal_req || sel_pulse) phase_d = ST_RSTI;
      ST_RSTI: if (tmr_q == TMR_W'(RST_CYC - 1)) phase_d = ST_INTG;
      ST_INTG: if (tmr_q == TMR_W'(INT_CYC - 1)) phase_d = ST_DSCH;
      ST_DSCH: if (dsch_exit) phase_d = ST_DONE;
      ST_DONE: begin
        if (cal_busy) phase_d = cal_last ? ST_IDLE : ST_RSTI;
        else if (tmr_q == TMR_W'(RES_W - 1)) phase_d = ST_IDLE;
      end
      default: phase_d = ST_IDLE;
    endcase
  end

  always_comb begin
    tmr_d = tmr_q;
    if (phase_d != phase_q) tmr_d = '0;
    else if (phase_q == ST_RSTI || phase_q == ST_INTG || phase_q == ST_DONE)
      tmr_d = tmr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= ST_IDLE;
      tmr_q   <= '0;
    end else begin
      phase_q <= phase_d;
      tmr_q   <= tmr_d;
    end
  end

  assign start_conv = (phase_q != ST_RSTI) && (phase_d == ST_RSTI);
  assign cal_start  = (phase_q == ST_IDLE) && cal_req;
  assign step_done  = (phase_q == ST_DONE) && cal_busy;
  assign ser_load   = dsch_exit && !cal_busy;
  assign int_rst    = (phase_q == ST_RSTI);
  assign int_en     = (phase_q == ST_INTG);
  assign dis_en     = (phase_q == ST_DSCH);
  assign ser_valid  = (phase_q == ST_DONE) && !cal_busy;

  assert_phase_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({int_rst, int_en, dis_en, ser_valid}));
  assert_dsch_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dis_en) |-> $past(int_en));
  assert_intg_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_en) |-> $past(int_rst));
  assert_dsch_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_en && !comp_in) |=> !dis_en);
endmodule

// File: rtl/intadc_dcnt.sv
module intadc_dcnt #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             dsch,
  input  logic             comp_in,
  output logic [RES_W-1:0] cnt,
  output logic             sat,
  output logic             ovf
);
  logic [RES_W-1:0] cnt_d;
  logic ovf_d;

  assign sat = &cnt;

  always_comb begin
    cnt_d = cnt;
    ovf_d = ovf;
    if (clr) begin
      cnt_d = '0;
      ovf_d = 1'b0;
    end else if (dsch && comp_in) begin
      if (sat) ovf_d = 1'b1;
      else     cnt_d = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      cnt <= cnt_d;
      ovf <= ovf_d;
    end
  end

  assert_sat_ovf_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dsch && comp_in && sat) |=> ovf);
  assert_cnt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!dsch && !clr) |=> $stable(cnt));
endmodule

// File: rtl/intadc_sar.sv
module intadc_sar #(
  parameter int TRIM_W = 9,
  parameter int RES_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cal_start,
  input  logic              step_done,
  input  logic [RES_W-1:0]  result,
  output logic [TRIM_W-1:0] trim,
  output logic              cal_busy,
  output logic              cal_last
);
  localparam logic [RES_W-1:0]  MID      = {1'b1, {(RES_W-1){1'b0}}};
  localparam logic [TRIM_W-1:0] TRIM_TOP = {1'b1, {(TRIM_W-1){1'b0}}};

  logic [TRIM_W-1:0] mask_q, mask_d, trim_d, kept;
  logic busy_d;

  assign cal_last = mask_q[0];
  assign kept     = (result >= MID) ? trim : (trim & ~mask_q);

  always_comb begin
    trim_d = trim;
    mask_d = mask_q;
    busy_d = cal_busy;
    if (cal_start) begin
      trim_d = TRIM_TOP;
      mask_d = TRIM_TOP;
      busy_d = 1'b1;
    end else if (step_done) begin
      if (mask_q[0]) begin
        trim_d = kept;
        mask_d = '0;
        busy_d = 1'b0;
      end else begin
        trim_d = kept | (mask_q >> 1);
        mask_d = mask_q >> 1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trim     <= TRIM_TOP;
      mask_q   <= '0;
      cal_busy <= 1'b0;
    end else begin
      trim     <= trim_d;
      mask_q   <= mask_d;
      cal_busy <= busy_d;
    end
  end

  assert_trim_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_busy |=> (cal_busy || $stable(trim)));
  assert_one_trial_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy |-> ($countones(mask_q) == 1));
endmodule

// File: rtl/intadc_ser.sv
module intadc_ser #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             shift,
  input  logic [RES_W-1:0] din,
  output logic             dout
);
  logic [RES_W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (load)       sh_d = din;
    else if (shift) sh_d = {sh_q[RES_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign dout = shift & sh_q[RES_W-1];
endmodule

// File: rtl/intadc_ctrl.sv
module intadc_ctrl #(
  parameter int RST_CYC = 4,
  parameter int INT_CYC = 16,
  parameter int RES_W   = 10,
  parameter int TRIM_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_pulse,
  input  logic              cal_req,
  input  logic              comp_in,
  output logic              int_rst,
  output logic              int_en,
  output logic              dis_en,
  output logic              ser_valid,
  output logic              ser_data,
  output logic              res_ovf,
  output logic              cal_busy,
  output logic [TRIM_W-1:0] trim_code
);
  logic start_conv, cal_start, step_done, ser_load, cnt_sat, cal_last;
  logic [RES_W-1:0] result;

  intadc_seq #(.RST_CYC(RST_CYC), .INT_CYC(INT_CYC), .RES_W(RES_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .sel_pulse(sel_pulse), .cal_req(cal_req),
    .comp_in(comp_in), .cnt_sat(cnt_sat), .cal_busy(cal_busy), .cal_last(cal_last),
    .start_conv(start_conv), .cal_start(cal_start), .step_done(step_done),
    .ser_load(ser_load), .int_rst(int_rst), .int_en(int_en), .dis_en(dis_en),
    .ser_valid(ser_valid)
  );

  intadc_dcnt #(.RES_W(RES_W)) u_dcnt (
    .clk(clk), .rst_n(rst_n), .clr(start_conv), .dsch(dis_en), .comp_in(comp_in),
    .cnt(result), .sat(cnt_sat), .ovf(res_ovf)
  );

  intadc_sar #(.TRIM_W(TRIM_W), .RES_W(RES_W)) u_sar (
    .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .step_done(step_done),
    .result(result), .trim(trim_code), .cal_busy(cal_busy), .cal_last(cal_last)
  );

  intadc_ser #(.RES_W(RES_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .load(ser_load), .shift(ser_valid),
    .din(result), .dout(ser_data)
  );
endmodule

// File: tb/test_intadc_ctrl.sv
`timescale 1ns/1ps
module test_intadc_ctrl;
  localparam int RST_CYC = 4;
  localparam int INT_CYC = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_pulse = 1'b0;
  logic cal_req = 1'b0;
  logic comp_in = 1'b0;
  logic int_rst, int_en, dis_en, ser_valid, ser_data, res_ovf, cal_busy;
  logic [8:0] trim_code;

  always #2.5 clk = ~clk;

  intadc_ctrl i_intadc_ctrl (
    .clk(clk), .rst_n(rst_n), .sel_pulse(sel_pulse), .cal_req(cal_req),
    .comp_in(comp_in), .int_rst(int_rst), .int_en(int_en), .dis_en(dis_en),
    .ser_valid(ser_valid), .ser_data(ser_data), .res_ovf(res_ovf),
    .cal_busy(cal_busy), .trim_code(trim_code)
  );

  int checks = 0;
  int errors = 0;
  int e_off = 37;
  int sig = 0;
  int k = 0;
  int frames = 0, bits = 0, last_res = 0, last_ovf = 0;
  logic [9:0] shreg = '0;
  int r_run = 0, i_run = 0, last_rst = 0, last_int = 0;
  int cal_conv = 0, excl_bad = 0;
  logic dis_prev = 1'b0;
  bit done_flag = 1'b0;

  function automatic int model_n(int s, int t);
    int n;
    n = 768 + e_off + s - t;
    return (n < 0) ? 0 : n;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // behavioural integrator and comparator, driven on the falling edge
  always @(negedge clk) begin
    if (dis_en) begin
      comp_in <= (k < model_n(sig, int'(trim_code)));
      k <= k + 1;
    end else begin
      k <= 0;
      comp_in <= 1'b0;
    end
  end

  // serial frame collector and phase-length monitor
  always @(negedge clk) begin
    if (ser_valid) begin
      shreg = {shreg[8:0], ser_data};
      bits++;
      if (bits == 10) begin
        last_res = int'(shreg);
        last_ovf = int'(res_ovf);
        frames++;
        bits = 0;
      end
    end else bits = 0;
    if (int_rst) r_run++;
    else if (r_run != 0) begin last_rst = r_run; r_run = 0; end
    if (int_en) i_run++;
    else if (i_run != 0) begin last_int = i_run; i_run = 0; end
    if (int'(int_rst) + int'(int_en) + int'(dis_en) + int'(ser_valid) > 1) excl_bad++;
    if (dis_en && !dis_prev && cal_busy) cal_conv++;
    dis_prev = dis_en;
  end

  task automatic pulse_sel();
    @(negedge clk) sel_pulse = 1'b1;
    @(negedge clk) sel_pulse = 1'b0;
  endtask

  task automatic conv(int s, string tag);
    int n, f0, expr, expo;
    sig = s;
    n = model_n(s, int'(trim_code));
    expr = (n > 1023) ? 1023 : n;
    expo = (n >= 1024) ? 1 : 0;
    f0 = frames;
    pulse_sel();
    wait (frames == f0 + 1);
    check(last_res == expr, {tag, " R3 result"}, last_res, expr);
    check(last_ovf == expo, {tag, " R4 ovf"}, last_ovf, expo);
  endtask

  task automatic conv_target(int target, string tag);
    conv(target - (768 + e_off - int'(trim_code)), tag);
  endtask

  task automatic calibrate(int e, bit with_sel);
    int f0, exp_t;
    e_off = e;
    sig = 0;
    f0 = frames;
    cal_conv = 0;
    @(negedge clk) begin cal_req = 1'b1; sel_pulse = with_sel; end
    @(negedge clk) begin cal_req = 1'b0; sel_pulse = 1'b0; end
    check(cal_busy == 1'b1, "R7 cal_busy raised", int'(cal_busy), 1);
    repeat (40) @(negedge clk);
    pulse_sel();   // R6: ignored during calibration
    wait (cal_busy == 1'b0);
    repeat (15) @(negedge clk);
    exp_t = 256 + e;
    check(int'(trim_code) == exp_t, "R8 final trim", int'(trim_code), exp_t);
    check(cal_conv == 9, "R7 trial conversions", cal_conv, 9);
    check(frames == f0, "R7/R6 no serial frame in calibration", frames, f0);
  endtask

  initial begin
    int f0, t0, rnd;
    rnd = $urandom(32'h1234_5678);
    repeat (3) @(negedge clk);
    // R1 reset state
    check({int_rst, int_en, dis_en, ser_valid, ser_data, res_ovf, cal_busy} == 7'd0,
          "R1 outputs low", int'({int_rst, int_en, dis_en, ser_valid, ser_data, res_ovf, cal_busy}), 0);
    check(trim_code == 9'd256, "R1 trim mid", int'(trim_code), 256);
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // directed corners of the discharge count
    conv_target(100, "dir100");
    check(last_rst == RST_CYC, "R2 reset length", last_rst, RST_CYC);
    check(last_int == INT_CYC, "R2 integrate length", last_int, INT_CYC);
    conv_target(0, "zero");
    conv_target(1, "one");
    conv_target(1023, "full");
    conv_target(1024, "sat");
    conv_target(1500, "over");
    conv_target(682, "pattern");   // R5 alternating bit pattern 1010101010

    // R6 and R9: pulses during a running conversion are ignored
    t0 = int'(trim_code);
    f0 = frames;
    sig = 60 - (768 + e_off - t0);
    pulse_sel();
    wait (int_en == 1'b1);
    @(negedge clk) begin sel_pulse = 1'b1; cal_req = 1'b1; end
    @(negedge clk) begin sel_pulse = 1'b0; cal_req = 1'b0; end
    wait (frames == f0 + 1);
    repeat (40) @(negedge clk);
    check(frames == f0 + 1, "R6 one frame only", frames, f0 + 1);
    check(cal_busy == 1'b0, "R9 cal_req ignored", int'(cal_busy), 0);
    check(int'(trim_code) == t0, "R9 trim unchanged", int'(trim_code), t0);
    check(last_res == 60, "R5 frame value", last_res, 60);

    // calibrations: random offset (cal_req and sel_pulse together), then the extremes
    calibrate(int'($urandom_range(0, 400)) - 200, 1'b1);
    for (int i = 0; i < 12; i++) conv(int'($urandom_range(0, 1200)) - 600, "rand");
    calibrate(255, 1'b0);
    conv(10, "after_hi");
    calibrate(-256, 1'b0);
    conv(-5, "after_lo");
    for (int i = 0; i < 6; i++) conv(int'($urandom_range(0, 1100)) - 512, "rand2");
    check(excl_bad == 0, "R2 phase exclusivity", excl_bad, 0);

    done_flag = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule